// File: doc/BRIEF.md
# Flash Block-Lock and Status Controller

This block is the command-side controller of a block-erasable flash array. It does not contain the storage cells. It accepts one decoded operation per cycle from a host port. The operations are data write, single-block erase, erase of all unlocked blocks, block lock, write-protect enable, write-protect disable, status clear, erase suspend and erase resume. It keeps one lock bit per block and a global write-protect mode. A down-counter stands in for the duration of each program or erase.

The controller drives a ready line and an 8-bit status byte. The status byte holds sticky error flags that software clears explicitly.

The programming-voltage level arrives as one digital input. It is sampled only at the moment a write or erase is accepted.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The status byte is {ready, suspended, erase_err, write_err, vpp_low, 3'b000}, so bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is write error, bit 3 is low-voltage abort, and bits 2..0 always read 0. After reset the status byte reads 8'h80.
- R2: After reset every block counts as locked, so writes and single-block erases are refused. This holds until a write-protect enable or write-protect disable command is accepted.
- R3: A write or single-block erase to a locked block is refused. The refusal raises no busy period and sets status bits 5 and 4. The lock check comes before the voltage check, so a refused command never sets bit 3.
- R4: Erase-all is not held back by the post-reset lock-out. It is busy for ERASE_CYC cycles. It leaves every set lock bit set, because locked blocks are skipped.
- R5: Lock bits count only while write protect is enabled. While write protect is disabled, every block accepts writes and erases.
- R6: A lock command is accepted only while write protect is disabled. Otherwise it is rejected: the lock bit is unchanged and status bit 4 is set.
- R7: vpp_ok is sampled when a write, erase or erase-all is accepted. If it is low, the operation aborts with no busy period and status bit 3 is set. A change of vpp_ok during a running operation has no effect.
- R8: An accepted write holds ready low for exactly WRITE_CYC cycles. An accepted erase or erase-all holds ready low for exactly ERASE_CYC cycles, counted from the clock edge that accepts it.
- R9: A completed single-block erase clears the lock bit of that block and of no other block.
- R10: Status bits 5, 4 and 3 are sticky and accumulate across operations. A status clear command, accepted only while ready, resets all three.
- R11: While an operation runs and is not suspended, every command except suspend is ignored.
- R12: A suspend during an erase or erase-all freezes the count, sets bit 6 and raises ready. A suspend in the last busy cycle is ignored, and so is a suspend during a write. While suspended, only resume is accepted. Resume clears bit 6 and the operation finishes the cycles it had left.
- R13: The command codes on cmd_op are: 0 idle, 1 write, 2 block erase, 3 erase-all, 4 lock, 5 write-protect enable, 6 write-protect disable, 7 status clear, 8 suspend, 9 resume. Codes 10 to 15 are ignored. The block index is the top $clog2(NUM_BLOCKS) bits of cmd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Target address; the upper bits select the block |
| vpp_ok | input | 1 | Sampled programming-voltage-good level |
| ready | output | 1 | High when idle or suspended |
| status | output | 8 | Status byte |

## Verification
Assertions watch several behaviours on every cycle:
- the counter stepping down by one while running and holding while frozen;
- sticky error bits that fall only on a clear;
- refusals and voltage aborts that never raise busy;
- write-protect disable lifting both the post-reset lock-out and the protect mode;
- an erased block's lock bit reading 0 afterwards;
- the error bits staying put while commands are ignored during a run.

Other behaviours only the bench's scenarios can show, and it compares against a behavioural model on every cycle. These are:
- the lock-before-voltage priority;
- erase-all skipping locked blocks;
- lock bits taking effect only under write protect;
- the exact busy lengths across a suspend and resume.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [3:0] {
    OP_IDLE      = 4'd0,
    OP_WRITE     = 4'd1,
    OP_ERASE     = 4'd2,
    OP_ERASE_ALL = 4'd3,
    OP_LOCK      = 4'd4,
    OP_WP_ON     = 4'd5,
    OP_WP_OFF    = 4'd6,
    OP_CLR_STAT  = 4'd7,
    OP_SUSPEND   = 4'd8,
    OP_RESUME    = 4'd9
  } flc_op_e;

  typedef enum logic [1:0] {
    K_NONE      = 2'd0,
    K_WRITE     = 2'd1,
    K_ERASE     = 2'd2,
    K_ERASE_ALL = 2'd3
  } flc_kind_e;

  // Status byte packing: ready, suspended, erase error, write error, vpp low.
  function automatic logic [7:0] pack_status(input logic rdy, input logic susp,
                                             input logic es, input logic ws,
                                             input logic vl);
    return {rdy, susp, es, ws, vl, 3'b000};
  endfunction

  // Busy length chosen for an accepted operation.
  function automatic int unsigned op_cycles(input flc_kind_e k,
                                            input int unsigned wr_cyc,
                                            input int unsigned er_cyc);
    return (k == K_WRITE) ? wr_cyc : er_cyc;
  endfunction

endpackage

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             freeze,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1)) && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (start)               cnt_q <= load;
    else if (busy && !freeze)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // R8: a running, unfrozen count steps down by exactly one per cycle
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !freeze && !start) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R12: a frozen count holds its value
  a_r12_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && freeze) |=> $stable(cnt_q));

endmodule

// File: rtl/flc_lock_bank.sv
module flc_lock_bank #(
  parameter int NB    = 32,
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_on,
  input  logic             wp_off,
  input  logic             lock_en,
  input  logic [BLK_W-1:0] lock_blk,
  input  logic             erase_done,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic [BLK_W-1:0] q_blk,
  output logic             q_locked,
  output logic             wp_mode
);

  logic [NB-1:0] lk_q;
  logic          pwr_lock_q;
  logic          wp_q;
  logic [NB-1:0] lk_set;
  logic [NB-1:0] lk_clr;

  for (genvar g = 0; g < NB; g++) begin : g_blk
    assign lk_set[g] = lock_en    && (lock_blk  == BLK_W'(g));
    assign lk_clr[g] = erase_done && (erase_blk == BLK_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_q <= '0;
    else        lk_q <= (lk_q | lk_set) & ~lk_clr;
  end

  // After reset every block counts as locked until protection is set explicitly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_lock_q <= 1'b1;
      wp_q       <= 1'b1;
    end else if (wp_on) begin
      pwr_lock_q <= 1'b0;
      wp_q       <= 1'b1;
    end else if (wp_off) begin
      pwr_lock_q <= 1'b0;
      wp_q       <= 1'b0;
    end
  end

  assign q_locked = pwr_lock_q | (wp_q & lk_q[q_blk]);
  assign wp_mode  = wp_q;

  // R5: disabling write protect lifts the reset lock-out and protect mode
  a_r5_wp_off_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp_off |=> (!wp_q && !pwr_lock_q));

  // R9: a finished block erase leaves that block's lock bit clear
  a_r9_erase_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !lk_q[$past(erase_blk)]);

endmodule

// File: rtl/flc_status_reg.sv
module flc_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_es,
  input  logic       set_ws,
  input  logic       set_vl,
  input  logic       clr,
  input  logic       rdy,
  input  logic       susp,
  output logic [7:0] stat
);
  import flc_pkg::*;

  logic es_q, ws_q, vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q <= 1'b0;
      ws_q <= 1'b0;
      vl_q <= 1'b0;
    end else if (clr) begin
      es_q <= 1'b0;
      ws_q <= 1'b0;
      vl_q <= 1'b0;
    end else begin
      es_q <= es_q | set_es;
      ws_q <= ws_q | set_ws;
      vl_q <= vl_q | set_vl;
    end
  end

  assign stat = pack_status(rdy, susp, es_q, ws_q, vl_q);

  // R10: error flags stay up until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (es_q || ws_q || vl_q)) |=>
      ((es_q || !$past(es_q)) && (ws_q || !$past(ws_q)) && (vl_q || !$past(vl_q))));

  // R10: a clear empties all three flags
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!es_q && !ws_q && !vl_q));

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
  parameter int NUM_BLOCKS = 32,
  parameter int ADDR_W     = 18,
  parameter int WRITE_CYC  = 8,
  parameter int ERASE_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              vpp_ok,
  output logic              ready,
  output logic [7:0]        status
);
  import flc_pkg::*;

  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int OFFS_W = ADDR_W - BLK_W;
  localparam int CNT_W  = $clog2(ERASE_CYC + 1);

  flc_op_e          op;
  logic [BLK_W-1:0] blk;
  logic             unused_addr_bits;

  assign op               = flc_op_e'(cmd_op);
  assign blk              = cmd_addr[ADDR_W-1 -: BLK_W];
  assign unused_addr_bits = ^cmd_addr[OFFS_W-1:0];

  // Operation state
  logic             busy, done_evt;
  logic             susp_q;
  flc_kind_e        kind_q;
  logic [BLK_W-1:0] blk_q;
  logic             q_locked, wp_mode;

  logic idle;
  assign idle = !busy;

  // Named command events
  logic acc_wr, acc_er, acc_all;
  logic refuse_evt, vpp_abort_evt, start_evt;
  logic lock_try, lock_ok, lock_rej;
  logic wp_on_evt, wp_off_evt, clr_evt;
  logic suspend_evt, resume_evt, erase_done;
  flc_kind_e        start_kind;
  logic [CNT_W-1:0] start_load;

  assign acc_wr  = cmd_valid && idle && (op == OP_WRITE);
  assign acc_er  = cmd_valid && idle && (op == OP_ERASE);
  assign acc_all = cmd_valid && idle && (op == OP_ERASE_ALL);

  assign refuse_evt    = (acc_wr || acc_er) && q_locked;
  assign vpp_abort_evt = ((acc_wr || acc_er) && !q_locked && !vpp_ok) ||
                         (acc_all && !vpp_ok);
  assign start_evt     = ((acc_wr || acc_er) && !q_locked && vpp_ok) ||
                         (acc_all && vpp_ok);

  assign start_kind = acc_wr ? K_WRITE : (acc_er ? K_ERASE : K_ERASE_ALL);
  assign start_load = CNT_W'(op_cycles(start_kind, WRITE_CYC, ERASE_CYC));

  assign lock_try = cmd_valid && idle && (op == OP_LOCK);
  assign lock_ok  = lock_try && !wp_mode;
  assign lock_rej = lock_try && wp_mode;

  assign wp_on_evt  = cmd_valid && idle && (op == OP_WP_ON);
  assign wp_off_evt = cmd_valid && idle && (op == OP_WP_OFF);
  assign clr_evt    = cmd_valid && idle && (op == OP_CLR_STAT);

  assign suspend_evt = cmd_valid && busy && !susp_q && !done_evt &&
                       (op == OP_SUSPEND) &&
                       (kind_q == K_ERASE || kind_q == K_ERASE_ALL);
  assign resume_evt  = cmd_valid && susp_q && (op == OP_RESUME);

  assign erase_done = done_evt && (kind_q == K_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_NONE;
      blk_q  <= '0;
    end else if (start_evt) begin
      kind_q <= start_kind;
      blk_q  <= blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           susp_q <= 1'b0;
    else if (suspend_evt) susp_q <= 1'b1;
    else if (resume_evt)  susp_q <= 1'b0;
  end

  flc_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_evt),
    .load   (start_load),
    .freeze (susp_q),
    .busy   (busy),
    .done   (done_evt)
  );

  flc_lock_bank #(.NB(NUM_BLOCKS), .BLK_W(BLK_W)) u_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_on      (wp_on_evt),
    .wp_off     (wp_off_evt),
    .lock_en    (lock_ok),
    .lock_blk   (blk),
    .erase_done (erase_done),
    .erase_blk  (blk_q),
    .q_blk      (blk),
    .q_locked   (q_locked),
    .wp_mode    (wp_mode)
  );

  assign ready = !busy || susp_q;

  flc_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_es (refuse_evt),
    .set_ws (refuse_evt || lock_rej),
    .set_vl (vpp_abort_evt),
    .clr    (clr_evt),
    .rdy    (ready),
    .susp   (susp_q),
    .stat   (status)
  );

  // R3: a refused write or erase never starts a busy period
  a_r3_refuse_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> (ready && status[5] && status[4]));

  // R7: a low-voltage abort flags bit 3 and stays ready
  a_r7_vpp_abort: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_abort_evt |=> (ready && status[3]));

  // R11: commands during a running operation leave the error flags alone
  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !susp_q && cmd_valid) |=> $stable(status[5:3]));

  // R12: resume puts the controller back to busy
  a_r12_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> (!ready && !status[6]));

endmodule

// File: tb/flash_lock_ctrl_tb.sv
module flash_lock_ctrl_tb;

  localparam int NB  = 32;
  localparam int AW  = 18;
  localparam int WC  = 6;
  localparam int EC  = 20;
  localparam int BW  = $clog2(NB);

  // Command codes (R13)
  localparam int C_WR = 1, C_ER = 2, C_ALL = 3, C_LOCK = 4, C_WPON = 5,
                 C_WPOFF = 6, C_CLR = 7, C_SUSP = 8, C_RES = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          vpp_ok = 1'b1;
  logic          ready;
  logic [7:0]    status;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .vpp_ok(vpp_ok), .ready(ready), .status(status));

  // ---------------- behavioural reference model ----------------
  bit m_lock[NB];
  bit m_pwr, m_wp, m_susp, m_es, m_ws, m_vl;
  int m_cnt, m_kind, m_blk;

  function automatic bit m_locked(int b);
    return m_pwr || (m_wp && m_lock[b]);
  endfunction

  function automatic logic [7:0] m_status();
    bit r;
    r = (m_cnt == 0) || m_susp;
    return {r, m_susp, m_es, m_ws, m_vl, 3'b000};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lock[i]) m_lock[i] = 1'b0;
      m_pwr = 1; m_wp = 1; m_susp = 0; m_es = 0; m_ws = 0; m_vl = 0;
      m_cnt = 0; m_kind = 0; m_blk = 0;
    end else begin
      bit b0, s0;
      int c0, op, tb_blk;
      b0 = (m_cnt != 0); s0 = m_susp; c0 = m_cnt;
      op = int'(cmd_op); tb_blk = int'(cmd_addr[AW-1 -: BW]);
      if (b0 && !s0) begin
        if (c0 == 1 && m_kind == C_ER) m_lock[m_blk] = 1'b0;
        m_cnt = c0 - 1;
      end
      if (cmd_valid) begin
        if (!b0) begin
          case (op)
            C_WR, C_ER: begin
              if (m_locked(tb_blk)) begin m_es = 1; m_ws = 1; end
              else if (!vpp_ok) m_vl = 1;
              else begin m_cnt = (op == C_WR) ? WC : EC; m_kind = op; m_blk = tb_blk; end
            end
            C_ALL: if (!vpp_ok) m_vl = 1; else begin m_cnt = EC; m_kind = C_ALL; end
            C_LOCK: if (m_wp) m_ws = 1; else m_lock[tb_blk] = 1'b1;
            C_WPON:  begin m_wp = 1; m_pwr = 0; end
            C_WPOFF: begin m_wp = 0; m_pwr = 0; end
            C_CLR:   begin m_es = 0; m_ws = 0; m_vl = 0; end
            default: ;
          endcase
        end else begin
          if (op == C_SUSP && !s0 && (m_kind == C_ER || m_kind == C_ALL) && c0 != 1) m_susp = 1;
          if (op == C_RES && s0) m_susp = 0;
        end
      end
    end
  end

  // Per-cycle comparison against the model (R1 layout, all behaviours)
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (status !== m_status() || ready !== m_status()[7]) begin
        fails++;
        $display("FAIL R1 model compare: status %h ready %b exp status %h", status, ready, m_status());
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic do_cmd(input int op, input int b, input bit v);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_addr  = {BW'(b), {(AW-BW){1'b0}}};
    vpp_ok    = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = '0;
    vpp_ok    = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d exp %0d", cyc, 20000);
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h80, "R1 reset status", status, 8'h80);

    // R2/R3: everything locked after reset
    do_cmd(C_WR, 3, 1);
    chk(ready && status == 8'hB0, "R2 write refused after reset", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_ER, 3, 1);
    chk(status == 8'hB0, "R2 erase refused after reset", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);
    chk(status == 8'h80, "R10 clear", status, 8'h80);
    do_cmd(C_WR, 3, 0);
    chk(status == 8'hB0, "R3 lock check before voltage", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);

    // R4: erase-all runs after reset
    do_cmd(C_ALL, 0, 1);
    chk(!ready, "R4 erase-all busy", ready, 0);
    wait_ready(n);
    chk(n == EC, "R8 erase-all length", n, EC);

    // R6: lock rejected while protect on
    do_cmd(C_LOCK, 5, 1);
    chk(status == 8'h90, "R6 lock rejected", status, 8'h90);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_WPOFF, 0, 1);
    do_cmd(C_LOCK, 5, 1);
    do_cmd(C_LOCK, 7, 1);
    chk(status == 8'h80, "R6 lock accepted", status, 8'h80);
    do_cmd(C_WR, 5, 1);
    wait_ready(n);
    chk(n == WC && status == 8'h80, "R5 lock ignored with protect off", n, WC);
    do_cmd(C_WPON, 0, 1);
    do_cmd(C_WR, 5, 1);
    chk(status == 8'hB0, "R5 locked write refused", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_WR, 6, 1);
    wait_ready(n);
    chk(n == WC, "R8 write length", n, WC);

    // R7 / R10: voltage abort and accumulation
    do_cmd(C_WR, 9, 0);
    chk(ready && status == 8'h88, "R7 vpp abort", status, 8'h88);
    do_cmd(C_WR, 5, 1);
    chk(status == 8'hB8, "R10 flags accumulate", status, 8'hB8);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_WR, 6, 1);
    vpp_ok = 1'b0;
    wait_ready(n);
    vpp_ok = 1'b1;
    chk(status == 8'h80, "R7 vpp not tracked during op", status, 8'h80);

    // R4: erase-all skips locked blocks
    do_cmd(C_ALL, 0, 1);
    wait_ready(n);
    do_cmd(C_WR, 7, 1);
    chk(status == 8'hB0, "R4 locked block kept lock", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);

    // R9: erase clears own lock only
    do_cmd(C_WPOFF, 0, 1);
    do_cmd(C_ER, 5, 1);
    wait_ready(n);
    chk(n == EC, "R8 block erase length", n, EC);
    do_cmd(C_WPON, 0, 1);
    do_cmd(C_WR, 5, 1);
    chk(!ready, "R9 erased block unlocked", ready, 0);
    wait_ready(n);
    do_cmd(C_WR, 7, 1);
    chk(status == 8'hB0, "R9 other block still locked", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);

    // R11: commands ignored while busy
    do_cmd(C_WR, 9, 0);
    do_cmd(C_WR, 6, 1);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_WPOFF, 0, 1);
    wait_ready(n);
    chk(status == 8'h88, "R11 clear ignored while busy", status, 8'h88);
    do_cmd(C_CLR, 0, 1);
    do_cmd(C_WR, 7, 1);
    chk(status == 8'hB0, "R11 protect change ignored while busy", status, 8'hB0);
    do_cmd(C_CLR, 0, 1);

    // R12: suspend / resume
    do_cmd(C_WPOFF, 0, 1);
    do_cmd(C_ER, 8, 1);
    repeat (5) @(negedge clk);
    do_cmd(C_SUSP, 0, 1);
    chk(ready && status == 8'hC0, "R12 suspended", status, 8'hC0);
    repeat (4) @(negedge clk);
    do_cmd(C_WR, 2, 1);
    chk(status == 8'hC0, "R12 write ignored while suspended", status, 8'hC0);
    do_cmd(C_RES, 0, 1);
    chk(!ready && status == 8'h00, "R12 resumed", status, 8'h00);
    wait_ready(n);
    chk(n == EC - 7, "R12 remaining count", n, EC - 7);
    do_cmd(C_WR, 6, 1);
    do_cmd(C_SUSP, 0, 1);
    chk(status == 8'h00, "R12 suspend ignored on write", status, 8'h00);
    wait_ready(n);
    chk(n == WC - 2, "R12 write length unchanged", n, WC - 2);

    // R13: unknown code ignored
    do_cmd(12, 4, 1);
    chk(ready && status == 8'h80, "R13 unknown code", status, 8'h80);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule